// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Program Engine

This block sits on the host side of a three-wire serial EEPROM (chip select, serial clock, serial data toward the memory and serial data back from it). It accepts one request at a time through a valid/ready handshake. A request is write-enable, write-disable, write-word or erase-word, and carries an address and a data word. The engine shifts the instruction out MSB first on a serial clock divided down from the system clock. It then drops chip select so the memory starts its self-timed program cycle.

For write and erase, the engine reselects the memory after the minimum deselect gap. It samples the returned data line on every system clock, without toggling the serial clock, until the memory reports ready. It then deselects again and signals done. If ready does not appear within a limit set on a port, it gives up and signals a timeout error instead. A write is sent as one instruction: the memory clears the cell itself, so no erase goes ahead of it.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: During and after reset, and whenever idle, `mw_cs`, `mw_sk` and `mw_di` are low, `req_ready` is high, and `done` and `timeout_err` are low.
- R2: An instruction is a start bit 1, then a two-bit opcode, then ADDR_W address bits MSB first. A write (req_cmd 2) uses opcode 01 and is followed by DATA_W data bits MSB first. An erase (req_cmd 3) uses opcode 11 and sends no data bits.
- R3: Write-enable (req_cmd 0) and write-disable (req_cmd 1) use opcode 00. The two top address bits are 11 for enable and 00 for disable, the remaining address bits are sent as 0, and `req_addr` has no effect on them.
- R4: Each bit occupies 2*SK_HALF system cycles, with `mw_sk` low for the first SK_HALF and high for the second. `mw_di` changes only when `mw_sk` falls or when the instruction starts, and `mw_sk` is never high while `mw_cs` is low.
- R5: After the last bit, `mw_cs`, `mw_sk` and `mw_di` are low for exactly CS_GAP cycles, and `mw_sk` stays low until the request finishes.
- R6: Write-enable and write-disable finish straight after that gap with a one-cycle `done`, without reselecting the memory.
- R7: For write and erase, `mw_cs` rises again after the gap and `mw_do` is sampled on each following clock. The first sample that reads 1 drops `mw_cs`, and after another CS_GAP cycles `done` pulses. `mw_do` has no effect outside this polling window.
- R8: If `poll_limit` consecutive samples read 0, `mw_cs` drops and `timeout_err` pulses after CS_GAP cycles. A limit of 0 acts as 1.
- R9: A request is accepted only while `req_ready` is high. Requests presented while a command is in progress have no effect, and the accepted command's fields are held internally.
- R10: `done` and `timeout_err` are single-cycle pulses, never both high, and appear in the same cycle `req_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_cmd | input | 2 | 0 enable, 1 disable, 2 write, 3 erase |
| req_addr | input | ADDR_W | Target address |
| req_data | input | DATA_W | Data word for a write |
| poll_limit | input | POLL_W | Busy samples allowed before timeout |
| mw_cs | output | 1 | Chip select to the memory |
| mw_sk | output | 1 | Serial clock to the memory |
| mw_di | output | 1 | Serial data to the memory |
| mw_do | input | 1 | Serial data / ready status from the memory |
| done | output | 1 | One-cycle success pulse |
| timeout_err | output | 1 | One-cycle timeout pulse |

## Verification
The bench predicts every pin in every cycle of each command and aims at the edges of the polling window: ready on the very first sample, ready on the last sample before the limit, ready one sample too late, and a limit of zero. A design that counted the limit off by one would finish with done where timeout is due, or the reverse. The bench drives the return line high during shifting and presents junk requests mid-command. A design that polled too early or re-latched its inputs would cut the frame short or corrupt its bits. Enable and disable are sent with a full-ones address, so a design that passed the address through would show ones in the don't-care bits.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [1:0] {
        CMD_WREN  = 2'd0,
        CMD_WRDIS = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_ERASE = 2'd3
    } mw_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2,
        ST_POLL  = 2'd3
    } mw_state_e;

endpackage

// File: rtl/mw_frame_fmt.sv
module mw_frame_fmt
    import mw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    localparam int FRAME_W = 3 + ADDR_W + DATA_W,
    localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic [1:0]         cmd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  data,
    output logic [FRAME_W-1:0] frame,
    output logic [LEN_W-1:0]   len,
    output logic               needs_poll
);

    localparam int SHORT_LEN = 3 + ADDR_W;

    // Frame is left-aligned: bit FRAME_W-1 leaves first.
    always_comb begin
        case (mw_cmd_e'(cmd))
            CMD_WREN: begin
                frame      = {1'b1, 2'b00, 2'b11, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
                len        = LEN_W'(SHORT_LEN);
                needs_poll = 1'b0;
            end
            CMD_WRDIS: begin
                frame      = {1'b1, 2'b00, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};
                len        = LEN_W'(SHORT_LEN);
                needs_poll = 1'b0;
            end
            CMD_WRITE: begin
                frame      = {1'b1, 2'b01, addr, data};
                len        = LEN_W'(FRAME_W);
                needs_poll = 1'b1;
            end
            default: begin
                frame      = {1'b1, 2'b11, addr, {DATA_W{1'b0}}};
                len        = LEN_W'(SHORT_LEN);
                needs_poll = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mw_sk_div.sv
module mw_sk_div #(
    parameter int HALF = 2,
    localparam int CW = $clog2(HALF + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == CW'(HALF - 1));

    always_comb begin
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/mw_poll_timer.sv
module mw_poll_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    // Current sample is number cnt_q (from 0); it is the last one allowed
    // when cnt_q + 1 reaches the limit. A zero limit expires at once.
    assign expired = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};

    always_comb begin
        if (run) cnt_d = cnt_q + 1'b1;
        else     cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
    import mw_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int SK_HALF = 2,
    parameter int CS_GAP  = 3,
    parameter int POLL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              mw_cs,
    output logic              mw_sk,
    output logic              mw_di,
    input  logic              mw_do,
    output logic              done,
    output logic              timeout_err
);

    localparam int FRAME_W = 3 + ADDR_W + DATA_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam int GAP_W   = $clog2(CS_GAP + 1);

    typedef struct packed {
        mw_state_e          st;
        logic [FRAME_W-1:0] sh;
        logic [LEN_W-1:0]   left;
        logic               cs;
        logic               sk;
        logic               di;
        logic [GAP_W-1:0]   gap;
        logic               poll_req;
        logic               polled;
        logic               fail;
        logic               done;
        logic               err;
    } regs_t;

    regs_t q, d;

    logic [FRAME_W-1:0] fmt_frame;
    logic [LEN_W-1:0]   fmt_len;
    logic               fmt_poll;
    logic               sk_tick;
    logic               poll_expired;

    mw_frame_fmt #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fmt (
        .cmd        (req_cmd),
        .addr       (req_addr),
        .data       (req_data),
        .frame      (fmt_frame),
        .len        (fmt_len),
        .needs_poll (fmt_poll)
    );

    mw_sk_div #(
        .HALF (SK_HALF)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.st == ST_SHIFT),
        .tick  (sk_tick)
    );

    mw_poll_timer #(
        .W (POLL_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.st == ST_POLL),
        .limit   (poll_limit),
        .expired (poll_expired)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st       = ST_SHIFT;
                    d.sh       = fmt_frame;
                    d.left     = fmt_len - LEN_W'(1);
                    d.cs       = 1'b1;
                    d.sk       = 1'b0;
                    d.di       = fmt_frame[FRAME_W-1];
                    d.poll_req = fmt_poll;
                    d.polled   = 1'b0;
                    d.fail     = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (sk_tick) begin
                    if (!q.sk) begin
                        d.sk = 1'b1;
                    end else begin
                        d.sk = 1'b0;
                        if (q.left == '0) begin
                            d.st  = ST_GAP;
                            d.cs  = 1'b0;
                            d.di  = 1'b0;
                            d.gap = '0;
                        end else begin
                            d.sh   = q.sh << 1;
                            d.di   = q.sh[FRAME_W-2];
                            d.left = q.left - LEN_W'(1);
                        end
                    end
                end
            end
            ST_GAP: begin
                if (q.gap == GAP_W'(CS_GAP - 1)) begin
                    if (q.poll_req && !q.polled) begin
                        d.st = ST_POLL;
                        d.cs = 1'b1;
                    end else begin
                        d.st   = ST_IDLE;
                        d.done = !q.fail;
                        d.err  = q.fail;
                    end
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            default: begin
                if (mw_do || poll_expired) begin
                    d.st     = ST_GAP;
                    d.cs     = 1'b0;
                    d.gap    = '0;
                    d.polled = 1'b1;
                    d.fail   = !mw_do;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign mw_cs       = q.cs;
    assign mw_sk       = q.sk;
    assign mw_di       = q.di;
    assign done        = q.done;
    assign timeout_err = q.err;

endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
module mw_eeprom_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic mw_cs,
    input logic mw_sk,
    input logic mw_di,
    input logic done,
    input logic timeout_err
);

    AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mw_cs && !mw_sk)); // R1

    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        mw_sk |-> mw_cs); // R4

    AST_DI_HELD_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mw_sk |=> (!mw_sk || $stable(mw_di))); // R4

    AST_DI_HELD_SK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_cs && !mw_sk && $past(mw_cs) && !$past(mw_sk)) |-> $stable(mw_di)); // R4

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mw_cs && !req_ready)); // R9

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout_err) |=> !(done || timeout_err)); // R10

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout_err)); // R10

    AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout_err) |-> (req_ready && !mw_cs)); // R6

endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .mw_cs       (mw_cs),
    .mw_sk       (mw_sk),
    .mw_di       (mw_di),
    .done        (done),
    .timeout_err (timeout_err)
);

// File: tb/tb_mw_eeprom_ctrl.sv
module tb_mw_eeprom_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 8;
    localparam int DW   = 16;
    localparam int HALF = 2;
    localparam int GAP  = 3;
    localparam int PW   = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [1:0]    req_cmd;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic [PW-1:0] poll_limit;
    logic          mw_cs, mw_sk, mw_di, mw_do;
    logic          done, timeout_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_ctrl #(
        .ADDR_W (AW), .DATA_W (DW), .SK_HALF (HALF), .CS_GAP (GAP), .POLL_W (PW)
    ) dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_cmd (req_cmd), .req_addr (req_addr), .req_data (req_data),
        .poll_limit (poll_limit), .mw_cs (mw_cs), .mw_sk (mw_sk), .mw_di (mw_di),
        .mw_do (mw_do), .done (done), .timeout_err (timeout_err)
    );

    function automatic logic [5:0] pins();
        return {req_ready, mw_cs, mw_sk, mw_di, done, timeout_err};
    endfunction

    task automatic check_pins(input string tag, input int cyc, input logic [5:0] exp);
        logic [5:0] act;
        act = pins();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d {rdy,cs,sk,di,done,err} actual=%b expected=%b",
                     tag, cyc, act, exp);
        end
    endtask

    // Expected bit stream built from the requirement text.
    task automatic build_frame(input int cmd, input int addr, input int data, ref bit fr[$]);
        fr.delete();
        fr.push_back(1'b1);
        case (cmd)
            2: begin fr.push_back(1'b0); fr.push_back(1'b1); end
            3: begin fr.push_back(1'b1); fr.push_back(1'b1); end
            default: begin fr.push_back(1'b0); fr.push_back(1'b0); end
        endcase
        for (int i = AW - 1; i >= 0; i--) begin
            if (cmd == 0)      fr.push_back(i >= AW - 2);
            else if (cmd == 1) fr.push_back(1'b0);
            else               fr.push_back(addr[i]);
        end
        if (cmd == 2)
            for (int i = DW - 1; i >= 0; i--) fr.push_back(data[i]);
    endtask

    // Issue one request and compare every pin against the model each cycle.
    task automatic run_cmd(input int cmd, input int addr, input int data,
                           input int busy, input int lim, input bit junk);
        bit fr[$];
        int len, tshift, p0, lm, kend, fin;
        bit needs, rdy;
        logic [5:0] exp;
        string tag;
        build_frame(cmd, addr, data, fr);
        len    = fr.size();
        tshift = 2 * HALF * len;
        p0     = tshift + GAP;
        needs  = (cmd >= 2);
        lm     = (lim < 1) ? 1 : lim;
        rdy    = (busy <= lm - 1);
        kend   = rdy ? busy : lm - 1;
        fin    = needs ? (p0 + 1 + kend + GAP) : p0;

        req_valid  = 1'b1;
        req_cmd    = 2'(cmd);
        req_addr   = AW'(addr);
        req_data   = DW'(data);
        poll_limit = PW'(lim);
        mw_do      = 1'b0;

        for (int j = 0; j <= fin + 1; j++) begin
            @(negedge clk);
            exp = 6'b0;
            if (j < tshift) begin
                exp[4] = 1'b1;
                exp[3] = (j % (2 * HALF)) >= HALF;
                exp[2] = fr[j / (2 * HALF)];
                tag = (cmd < 2) ? "R3 R4 frame" : "R2 R4 frame";
            end else if (j < p0) begin
                tag = "R5 gap";
            end else if (needs && j <= p0 + kend) begin
                exp[4] = 1'b1;
                tag = "R7 poll";
            end else begin
                tag = needs ? (rdy ? "R7 finish" : "R8 timeout") : "R6 finish";
            end
            if (j == fin) begin
                exp[5] = 1'b1;
                exp[1] = !needs || rdy;
                exp[0] = needs && !rdy;
                tag = {tag, " R10"};
            end
            if (j > fin) begin
                exp[5] = 1'b1;
                tag = "R10 R1 idle";
            end
            if (junk) tag = {tag, " R9"};
            check_pins(tag, j, exp);

            // Stimulus for the next edge.
            mw_do = (needs && j >= p0 && j <= p0 + kend && (j - p0) >= busy)
                    || (junk && j < p0);
            if (junk && j < p0) begin
                req_valid = 1'b1;
                req_cmd   = 2'd2;
                req_addr  = '1;
                req_data  = '1;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        mw_do     = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        req_valid  = 1'b0;
        req_cmd    = '0;
        req_addr   = '0;
        req_data   = '0;
        poll_limit = '0;
        mw_do      = 1'b0;
        repeat (3) @(negedge clk);
        check_pins("R1 in reset", 0, 6'b100000);
        rst_n = 1'b1;
        @(negedge clk);
        check_pins("R1 after reset", 0, 6'b100000);

        run_cmd(0, 8'hFF, 16'hFFFF, 0, 5, 1'b0);    // R3 enable, address ignored
        run_cmd(1, 8'hFF, 16'hFFFF, 0, 5, 1'b0);    // R3 disable
        run_cmd(2, 8'hA5, 16'h1234, 5, 20, 1'b0);   // R2 R7 write
        run_cmd(3, 8'h3C, 16'hBEEF, 0, 10, 1'b0);   // R2 R7 erase, instant ready
        run_cmd(2, 8'h0F, 16'h8001, 30, 8, 1'b0);   // R8 write timeout
        run_cmd(3, 8'h81, 16'h0000, 3, 0, 1'b0);    // R8 zero limit times out
        run_cmd(2, 8'h00, 16'hFFFF, 0, 0, 1'b0);    // R8 zero limit, ready first
        run_cmd(2, 8'h5A, 16'h0F0F, 6, 7, 1'b0);    // R7 ready on last sample
        run_cmd(3, 8'hC3, 16'h0000, 7, 7, 1'b0);    // R8 ready one too late
        run_cmd(2, 8'h96, 16'hC35A, 2, 9, 1'b1);    // R9 junk requests, R7 early mw_do
        run_cmd(1, 8'hAA, 16'h0000, 0, 3, 1'b1);    // R9 R3 junk during disable

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule